// File: doc/BRIEF.md
# Operate-Class Microinstruction Unit

This unit carries out one operate-class instruction of an 18-bit machine. The state it works on is a 19-bit ring made of a one-bit link above an 18-bit accumulator. A single instruction word can ask for several things at once. It can test the accumulator and the link and request a skip. It can clear and complement the link and the accumulator. It can OR a switch register into the accumulator, rotate the ring, and stop the machine. All skip tests use the state as it was before the instruction. The other actions are applied in a fixed order: clear, complement, switch OR, rotate.

A variant-select input enables the extended behaviour. In that mode the two rotate codes that are otherwise illegal become a 19-bit increment and a swap of the two halves of the accumulator. A user-mode input turns the privileged actions (switch OR and halt) into a privilege violation, and a violation cancels any skip. The unit does not fetch instructions or update the program counter; it only reports the skip request. Each word is presented with a valid strobe, and all results come out of registers one cycle later.

Top module: `opr_unit`

## Requirements
- R1: With word bit 9 clear, the skip flag is the OR of the tests selected by bit 6 (accumulator bit 17 set), bit 7 (accumulator zero) and bit 8 (link set); with none selected there is no skip.
- R2: With word bit 9 set, the skip flag is the AND of the inverted selected tests, so bit 9 alone gives an unconditional skip.
- R3: The zero test looks at the 18 accumulator bits only (the link is ignored), and the minus test looks only at accumulator bit 17; both use the state before the instruction.
- R4: Bit 12 clears the accumulator and bit 11 clears the link, and this happens before bit 0 complements the accumulator and bit 1 complements the link; clearing and complementing the link together leaves it set.
- R5: Bit 2 ORs the switch register into the accumulator after the clear and complement step; in user mode the accumulator is left without the OR and a privilege violation is flagged instead.
- R6: The rotate code {bit 10, bit 4, bit 3} selects rotate left by one (001), right by one (010), left by two (101) or right by two (110) of the 19-bit ring, with the link as its top bit; codes 000 and 100 do not rotate.
- R7: Rotate code 011 increments the 19-bit ring when the extended variant is selected; otherwise it raises the undefined flag and leaves the ring as it was after the switch step.
- R8: Rotate code 111 swaps bits 17:9 and 8:0 of the accumulator and keeps the link when the extended variant is selected; otherwise it raises the undefined flag and leaves the ring unchanged.
- R9: Bit 5 raises the halt flag outside user mode; in user mode it raises a privilege violation and no halt.
- R10: Any privilege violation forces the skip flag low.
- R11: After reset all outputs are zero. A word accepted with the valid strobe shows its results and a one-cycle output-valid pulse on the next clock. Without the strobe, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: the word and state on the inputs are valid this cycle |
| ir | input | 18 | Operate-class instruction word |
| link_in | input | 1 | Current link bit |
| ac_in | input | 18 | Current accumulator |
| sw_in | input | 18 | Switch register |
| user_mode | input | 1 | High when the machine runs in user mode |
| ext_en | input | 1 | Enables the extended variant (increment and half swap) |
| out_valid | output | 1 | Pulse: registered results below are new |
| link_out | output | 1 | Resulting link |
| ac_out | output | 18 | Resulting accumulator |
| skip_out | output | 1 | Skip request for the sequencer |
| halt_out | output | 1 | Halt request |
| priv_viol | output | 1 | Privilege violation flag |
| undef_op | output | 1 | Undefined rotate combination flag |

## Verification
All sixteen skip-field codes are swept against four states: zero state, link only, a negative accumulator, and a positive accumulator with the link set. This sweep separates OR sense from inverted-AND sense, and it shows that the link does not affect the zero test. All sixteen clear/complement codes run on a mixed pattern, which shows the clear-before-complement order. All eight rotate codes run in both variants on an asymmetric pattern, so that a wrong direction, a wrong step or a wrong half shows up. Privileged bits are tried with and without user mode while a skip is pending. A pseudo-random stream then covers combinations of all fields.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int IR_W = 18;

  localparam int B_CMA   = 0;
  localparam int B_CML   = 1;
  localparam int B_ORSW  = 2;
  localparam int B_RL1   = 3;
  localparam int B_RR1   = 4;
  localparam int B_HALT  = 5;
  localparam int B_TMIN  = 6;
  localparam int B_TZERO = 7;
  localparam int B_TLINK = 8;
  localparam int B_REV   = 9;
  localparam int B_DBL   = 10;
  localparam int B_CLL   = 11;
  localparam int B_CLA   = 12;

  typedef enum logic [2:0] {
    ROT_NONE,
    ROT_L1,
    ROT_R1,
    ROT_L2,
    ROT_R2,
    ROT_INC,
    ROT_SWAP,
    ROT_BAD
  } rot_sel_e;

  function automatic rot_sel_e decode_rot(input logic [2:0] code, input logic ext);
    rot_sel_e r;
    case (code)
      3'b001:  r = ROT_L1;
      3'b010:  r = ROT_R1;
      3'b011:  r = ext ? ROT_INC : ROT_BAD;
      3'b101:  r = ROT_L2;
      3'b110:  r = ROT_R2;
      3'b111:  r = ext ? ROT_SWAP : ROT_BAD;
      default: r = ROT_NONE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/opr_skip_eval.sv
module opr_skip_eval #(
  parameter int W = 18
) (
  input  logic [3:0]   skip_field,
  input  logic         link,
  input  logic [W-1:0] ac,
  output logic         skip_raw
);
  localparam int NTEST = 3;

  logic [NTEST-1:0] tests;
  logic [NTEST-1:0] sel;
  logic             reverse;

  assign tests   = {link, (ac == '0), ac[W-1]};
  assign sel     = skip_field[NTEST-1:0];
  assign reverse = skip_field[NTEST];

  always_comb begin
    if (reverse) begin
      skip_raw = 1'b1;
      for (int i = 0; i < NTEST; i++) begin
        if (sel[i] && tests[i]) skip_raw = 1'b0;
      end
    end else begin
      skip_raw = 1'b0;
      for (int i = 0; i < NTEST; i++) begin
        if (sel[i] && tests[i]) skip_raw = 1'b1;
      end
    end
  end
endmodule

// File: rtl/opr_clr_cmp.sv
module opr_clr_cmp #(
  parameter int W = 18
) (
  input  logic         clr_ac,
  input  logic         clr_link,
  input  logic         cmp_ac,
  input  logic         cmp_link,
  input  logic         or_sw,
  input  logic         user,
  input  logic         link_i,
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] sw_i,
  output logic         link_o,
  output logic [W-1:0] ac_o,
  output logic         sw_viol
);
  logic         l_clr;
  logic [W-1:0] a_clr;
  logic         l_cmp;
  logic [W-1:0] a_cmp;

  always_comb begin
    l_clr = clr_link ? 1'b0 : link_i;
    a_clr = clr_ac ? '0 : ac_i;
    l_cmp = cmp_link ? ~l_clr : l_clr;
    a_cmp = cmp_ac ? ~a_clr : a_clr;
  end

  always_comb begin
    sw_viol = or_sw & user;
    link_o  = l_cmp;
    ac_o    = (or_sw && !user) ? (a_cmp | sw_i) : a_cmp;
  end
endmodule

// File: rtl/opr_rotator.sv
module opr_rotator
  import opr_pkg::*;
#(
  parameter int W = 18
) (
  input  rot_sel_e     sel,
  input  logic         link_i,
  input  logic [W-1:0] ac_i,
  output logic         link_o,
  output logic [W-1:0] ac_o,
  output logic         bad
);
  localparam int RW   = W + 1;
  localparam int HALF = W / 2;

  logic [RW-1:0] ring;
  logic [RW-1:0] res;

  assign ring = {link_i, ac_i};

  always_comb begin
    bad = 1'b0;
    case (sel)
      ROT_L1:   res = {ring[RW-2:0], ring[RW-1]};
      ROT_R1:   res = {ring[0], ring[RW-1:1]};
      ROT_L2:   res = {ring[RW-3:0], ring[RW-1:RW-2]};
      ROT_R2:   res = {ring[1:0], ring[RW-1:2]};
      ROT_INC:  res = ring + RW'(1);
      ROT_SWAP: res = {link_i, ac_i[HALF-1:0], ac_i[W-1:HALF]};
      ROT_BAD: begin
        res = ring;
        bad = 1'b1;
      end
      default:  res = ring;
    endcase
  end

  assign link_o = res[RW-1];
  assign ac_o   = res[W-1:0];
endmodule

// File: rtl/opr_unit.sv
module opr_unit
  import opr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [17:0]  ir,
  input  logic         link_in,
  input  logic [W-1:0] ac_in,
  input  logic [W-1:0] sw_in,
  input  logic         user_mode,
  input  logic         ext_en,
  output logic         out_valid,
  output logic         link_out,
  output logic [W-1:0] ac_out,
  output logic         skip_out,
  output logic         halt_out,
  output logic         priv_viol,
  output logic         undef_op
);
  logic         skip_raw;
  logic         l_mid;
  logic [W-1:0] a_mid;
  logic         sw_viol;
  rot_sel_e     rsel;
  logic         l_fin;
  logic [W-1:0] a_fin;
  logic         rot_bad;
  logic         halt_viol;
  logic         viol;
  logic         halt_req;
  logic         skip_eff;

  opr_skip_eval #(.W(W)) u_skip (
    .skip_field (ir[B_REV:B_TMIN]),
    .link       (link_in),
    .ac         (ac_in),
    .skip_raw   (skip_raw)
  );

  opr_clr_cmp #(.W(W)) u_cc (
    .clr_ac   (ir[B_CLA]),
    .clr_link (ir[B_CLL]),
    .cmp_ac   (ir[B_CMA]),
    .cmp_link (ir[B_CML]),
    .or_sw    (ir[B_ORSW]),
    .user     (user_mode),
    .link_i   (link_in),
    .ac_i     (ac_in),
    .sw_i     (sw_in),
    .link_o   (l_mid),
    .ac_o     (a_mid),
    .sw_viol  (sw_viol)
  );

  assign rsel = decode_rot({ir[B_DBL], ir[B_RR1], ir[B_RL1]}, ext_en);

  opr_rotator #(.W(W)) u_rot (
    .sel    (rsel),
    .link_i (l_mid),
    .ac_i   (a_mid),
    .link_o (l_fin),
    .ac_o   (a_fin),
    .bad    (rot_bad)
  );

  assign halt_viol = ir[B_HALT] & user_mode;
  assign halt_req  = ir[B_HALT] & ~user_mode;
  assign viol      = halt_viol | sw_viol;
  assign skip_eff  = skip_raw & ~viol;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      link_out  <= 1'b0;
      ac_out    <= '0;
      skip_out  <= 1'b0;
      halt_out  <= 1'b0;
      priv_viol <= 1'b0;
      undef_op  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        link_out  <= l_fin;
        ac_out    <= a_fin;
        skip_out  <= skip_eff;
        halt_out  <= halt_req;
        priv_viol <= viol;
        undef_op  <= rot_bad;
      end
    end
  end
endmodule

// File: rtl/opr_unit_chk.sv
module opr_unit_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [17:0]  ir,
  input logic         user_mode,
  input logic         ext_en,
  input logic         out_valid,
  input logic         link_out,
  input logic [W-1:0] ac_out,
  input logic         skip_out,
  input logic         halt_out,
  input logic         priv_viol,
  input logic         undef_op
);
  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(ac_out) && $stable(link_out) && $stable(skip_out)
                   && $stable(halt_out) && $stable(priv_viol) && $stable(undef_op)));

  // R10
  skip_supp_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && priv_viol) |-> !skip_out);

  // R9
  halt_user_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && user_mode && ir[5]) |=> (priv_viol && !halt_out));

  // R9
  halt_sup_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !user_mode && ir[5]) |=> halt_out);

  // R5
  orsw_user_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && user_mode && ir[2]) |=> priv_viol);

  // R7
  undef_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ext_en) |=> !undef_op);

  // R2
  uncond_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ir[9:6] == 4'b1000 && !ir[5] && !ir[2]) |=> skip_out);
endmodule

bind opr_unit opr_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .ir        (ir),
  .user_mode (user_mode),
  .ext_en    (ext_en),
  .out_valid (out_valid),
  .link_out  (link_out),
  .ac_out    (ac_out),
  .skip_out  (skip_out),
  .halt_out  (halt_out),
  .priv_viol (priv_viol),
  .undef_op  (undef_op)
);

// File: tb/test_opr_unit.sv
`timescale 1ns/1ps
module test_opr_unit;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [17:0]  ir = '0;
  logic         link_in = 1'b0;
  logic [W-1:0] ac_in = '0;
  logic [W-1:0] sw_in = '0;
  logic         user_mode = 1'b0;
  logic         ext_en = 1'b0;
  logic         out_valid, link_out, skip_out, halt_out, priv_viol, undef_op;
  logic [W-1:0] ac_out;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic         link;
    logic [W-1:0] ac;
    logic         skip, halt, priv, undef;
    string        tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  opr_unit #(.W(W)) i_opr_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ir(ir), .link_in(link_in),
    .ac_in(ac_in), .sw_in(sw_in), .user_mode(user_mode), .ext_en(ext_en),
    .out_valid(out_valid), .link_out(link_out), .ac_out(ac_out),
    .skip_out(skip_out), .halt_out(halt_out), .priv_viol(priv_viol),
    .undef_op(undef_op)
  );

  // Reference model built from the requirement text
  function automatic exp_t model(input logic [17:0] w, input logic l, input logic [W-1:0] a,
                                 input logic [W-1:0] s, input logic u, input logic x,
                                 input string tag);
    exp_t e;
    logic         neg, zer, sk;
    logic [18:0]  r;
    logic [2:0]   rc;
    neg = a[17];
    zer = (a == 0);
    if (!w[9]) sk = (w[6] & neg) | (w[7] & zer) | (w[8] & l);
    else       sk = !(w[6] & neg) && !(w[7] & zer) && !(w[8] & l);
    if (w[12]) a = '0;
    if (w[11]) l = 1'b0;
    if (w[0])  a = ~a;
    if (w[1])  l = ~l;
    e.priv = 1'b0;
    if (w[2]) begin
      if (u) e.priv = 1'b1;
      else   a = a | s;
    end
    r = {l, a};
    e.undef = 1'b0;
    rc = {w[10], w[4], w[3]};
    if (rc == 3'd1)      r = {r[17:0], r[18]};
    else if (rc == 3'd2) r = {r[0], r[18:1]};
    else if (rc == 3'd5) r = {r[16:0], r[18:17]};
    else if (rc == 3'd6) r = {r[1:0], r[18:2]};
    else if (rc == 3'd3) begin
      if (x) r = r + 19'd1; else e.undef = 1'b1;
    end else if (rc == 3'd7) begin
      if (x) r = {r[18], r[8:0], r[17:9]}; else e.undef = 1'b1;
    end
    e.halt = 1'b0;
    if (w[5]) begin
      if (u) e.priv = 1'b1;
      else   e.halt = 1'b1;
    end
    e.skip = sk & ~e.priv;
    e.link = r[18];
    e.ac   = r[17:0];
    e.tag  = tag;
    return e;
  endfunction

  task automatic send(input logic [17:0] w, input logic l, input logic [W-1:0] a,
                      input logic [W-1:0] s, input logic u, input logic x, input string tag);
    @(negedge clk);
    ir = w; link_in = l; ac_in = a; sw_in = s; user_mode = u; ext_en = x;
    in_valid = 1'b1;
    sb.push_back(model(w, l, a, s, u, x, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_tests++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R11: output valid with no pending item (got 1, expected 0)");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if ({link_out, ac_out} !== {e.link, e.ac}) begin
          n_fail++;
          $display("FAIL %s: link:ac actual %o expected %o", e.tag, {link_out, ac_out}, {e.link, e.ac});
        end else if ({skip_out, halt_out, priv_viol, undef_op} !== {e.skip, e.halt, e.priv, e.undef}) begin
          n_fail++;
          $display("FAIL %s: skip/halt/priv/undef actual %b expected %b", e.tag,
                   {skip_out, halt_out, priv_viol, undef_op}, {e.skip, e.halt, e.priv, e.undef});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] held_ac;
    logic [5:0]   held_f;
    logic [31:0]  lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    n_tests++;
    if ({out_valid, link_out, ac_out, skip_out, halt_out, priv_viol, undef_op} !== '0) begin
      n_fail++;
      $display("FAIL R11: reset outputs actual %b expected 0",
               {out_valid, link_out, ac_out, skip_out, halt_out, priv_viol, undef_op});
    end

    // R1 R2 R3: skip field sweep over four states
    for (int f = 0; f < 16; f++) begin
      send(18'(f << 6), 1'b0, 18'o000000, '0, 1'b0, 1'b0, f[3] ? "R2" : "R1");
      send(18'(f << 6), 1'b1, 18'o000000, '0, 1'b0, 1'b0, "R3");
      send(18'(f << 6), 1'b0, 18'o400000, '0, 1'b0, 1'b0, "R3");
      send(18'(f << 6), 1'b1, 18'o000005, '0, 1'b0, 1'b0, f[3] ? "R2" : "R1");
    end
    // R4: clear/complement codes
    for (int c = 0; c < 16; c++) begin
      logic [17:0] w;
      w = 18'((c[3] << 12) | (c[2] << 11) | (c[1] << 1) | c[0]);
      send(w, 1'b1, 18'o123456, '0, 1'b0, 1'b0, "R4");
      send(w, 1'b0, 18'o000000, '0, 1'b0, 1'b0, "R4");
    end
    // R5: switch OR in both modes
    send(18'o000004, 1'b0, 18'o070000, 18'o000707, 1'b0, 1'b0, "R5");
    send(18'o000004, 1'b0, 18'o070000, 18'o000707, 1'b1, 1'b0, "R5");
    send(18'o010004, 1'b0, 18'o777777, 18'o000707, 1'b0, 1'b0, "R5");
    // R6 R7 R8: rotate codes in both variants
    for (int x = 0; x < 2; x++) begin
      for (int rc = 0; rc < 8; rc++) begin
        logic [17:0] w;
        w = 18'((rc[2] << 10) | (rc[1] << 4) | (rc[0] << 3));
        send(w, 1'b1, 18'o400123, '0, 1'b0, x[0], (rc == 3) ? "R7" : (rc == 7) ? "R8" : "R6");
        send(w, 1'b0, 18'o777777, '0, 1'b0, x[0], (rc == 3) ? "R7" : (rc == 7) ? "R8" : "R6");
      end
    end
    // R9 R10: halt and violations with a pending skip
    send(18'o001040, 1'b0, 18'o000001, '0, 1'b0, 1'b0, "R9");
    send(18'o001040, 1'b0, 18'o000001, '0, 1'b1, 1'b0, "R9");
    send(18'o001000, 1'b0, 18'o000001, '0, 1'b1, 1'b0, "R10");
    send(18'o001004, 1'b0, 18'o000001, 18'o1, 1'b1, 1'b0, "R10");
    send(18'o000240, 1'b0, 18'o000000, '0, 1'b1, 1'b0, "R10");
    // pseudo-random mix
    lfsr = 32'hACE1_2345;
    for (int k = 0; k < 300; k++) begin
      logic [17:0] w, a, s;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      w = lfsr[17:0];
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = (lfsr[3:0] == 0) ? 18'o0 : lfsr[25:8];
      s = lfsr[31:14];
      send(w, lfsr[4], a, s, lfsr[5], lfsr[6], "R1");
    end
    idle();
    repeat (2) @(negedge clk);
    // R11 hold without strobe
    held_ac = ac_out;
    held_f  = {link_out, skip_out, halt_out, priv_viol, undef_op, out_valid};
    ir = 18'o017777; ac_in = 18'o555555; link_in = 1'b1;
    repeat (4) @(negedge clk);
    n_tests++;
    if (ac_out !== held_ac || {link_out, skip_out, halt_out, priv_viol, undef_op, out_valid} !== held_f
        || held_f[0] !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: idle hold actual %o/%b expected %o/%b", ac_out,
               {link_out, skip_out, halt_out, priv_viol, undef_op, out_valid}, held_ac, held_f);
    end
    n_tests++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R11: results missing actual %0d pending expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule